// File: doc/BRIEF.md
# Drive status frame builder

This block assembles the status report that a disc drive hands to its host processor. Four byte-wide report fields (drive status, minute, second, frame) and one extension nibble arrive on a load strobe. The block splits each field into two nibbles and stores the nine data nibbles in byte-wide register slots that the host can read. A tenth slot holds a 4-bit checksum. The same clock edge that stores the data nibbles also stores the checksum, so the host never reads a frame whose checksum belongs to other data.

Every load also trims the host command-control register down to its two lowest bits. When the host has set the level-4 interrupt enable, the load also gives a one-cycle interrupt request. The register bank holds further slots next to the status frame: ten command slots, the control register and a fader register. Reset clears all of them. Host writes reach these extra slots but never reach the status frame. Reads are combinational by default; a parameter can add one register stage on the read path.

Top module: `drive_status_frame`

## Requirements
- R1: After reset, frame slots 0 to 8, the command slots (addresses 10 to 19), the control register (address 20) and the fader register (address 21) read 0x00, and the checksum slot (address 9) reads 0x0F.
- R2: A load stores field f (bits [8f+7:8f] of `fields_i`: f=0 status, 1 minute, 2 second, 3 frame) with its high nibble in slot 2f and its low nibble in slot 2f+1, and stores `ext_i` in slot 8. The upper four bits of every frame slot read zero. The new values are readable in the cycle after the load edge.
- R3: Slot 9 holds the bitwise inverse of the low 4 bits of the sum of the nine data nibbles. It is updated on the same edge as the data slots.
- R4: A load clears bits [7:2] of the control register and keeps bits [1:0]. A host write to the control register in the same cycle as a load is dropped.
- R5: With `irq_enable_i` high during a load, `irq_o` is high for exactly the one cycle after the load edge. With `irq_enable_i` low, the load gives no pulse.
- R6: Host writes update the command slots, the control register and the fader register. Host writes to addresses 0 to 9 are ignored.
- R7: Frame slots keep their values until the next load.
- R8: A read of an address above 21 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Export strobe; captures fields and raises the report |
| fields_i | input | 32 | Four byte fields: status, minute, second, frame (low byte first) |
| ext_i | input | 4 | Extension nibble |
| irq_enable_i | input | 1 | Level-4 interrupt enable from the host mask |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 5 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 5 | Host read address |
| rd_data_o | output | 8 | Host read data |
| irq_o | output | 1 | One-cycle interrupt request per enabled load |

## Verification
The assertions check three things on every cycle. The stored checksum must always match the stored data nibbles. The frame must stay unchanged between loads. After a load, the control register must keep only its low two bits, and the interrupt pulse must follow exactly the enabled loads. Only the bench scenarios can show the nibble placement for chosen field values, the checksum for chosen data, the default value of 0x0F after reset, and that writes to the frame addresses change nothing at the read port. The same holds for dropping a control write that collides with a load and for the zero read of unmapped addresses.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
   // Read-port variants selectable on the top module.
   typedef enum logic {
      RD_COMB = 1'b0,
      RD_FLOP = 1'b1
   } rd_mode_e;

   localparam int unsigned DSF_NIB_W      = 4;
   localparam int unsigned DSF_REG_W      = 8;
   localparam logic [3:0]  DSF_CKSUM_INIT = 4'hF;
endpackage

// File: rtl/dsf_checksum.sv
// Inverted nibble-sum checksum over a flattened nibble vector.
module dsf_checksum #(
   parameter int unsigned NIB_W    = 4,
   parameter int unsigned NUM_NIBS = 9
) (
   input  logic [NUM_NIBS*NIB_W-1:0] nibs_i,
   output logic [NIB_W-1:0]          cksum_o
);
   localparam int unsigned SUM_W = NIB_W + $clog2(NUM_NIBS + 1);

   if (NIB_W < 1) begin : g_bad_nib
      $error("dsf_checksum: NIB_W must be at least 1");
   end
   if (NUM_NIBS < 1) begin : g_bad_cnt
      $error("dsf_checksum: NUM_NIBS must be at least 1");
   end

   logic [SUM_W-1:0] acc [NUM_NIBS+1];
   assign acc[0] = '0;

   for (genvar i = 0; i < NUM_NIBS; i++) begin : g_acc
      assign acc[i+1] = acc[i] + {{(SUM_W-NIB_W){1'b0}}, nibs_i[i*NIB_W +: NIB_W]};
   end

   assign cksum_o = ~acc[NUM_NIBS][NIB_W-1:0];
endmodule

// File: rtl/dsf_frame_bank.sv
// Storage for the data nibbles plus the trailing checksum slot.
module dsf_frame_bank #(
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned DATA_NIBS  = 9,
   parameter logic [3:0]  CKSUM_INIT = 4'hF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_i,
   input  logic [DATA_NIBS*NIB_W-1:0]       data_i,
   input  logic [NIB_W-1:0]                 cksum_i,
   output logic [(DATA_NIBS+1)*NIB_W-1:0]   slots_o
);
   localparam int unsigned SLOTS = DATA_NIBS + 1;

   if (NIB_W > 4) begin : g_bad_nib
      $error("dsf_frame_bank: NIB_W above 4 is not supported by CKSUM_INIT");
   end

   logic [NIB_W-1:0] data_q [DATA_NIBS];
   logic [NIB_W-1:0] cksum_q;

   for (genvar i = 0; i < DATA_NIBS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)      data_q[i] <= '0;
         else if (load_i) data_q[i] <= data_i[i*NIB_W +: NIB_W];
      end
      assign slots_o[i*NIB_W +: NIB_W] = data_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cksum_q <= CKSUM_INIT[NIB_W-1:0];
      else if (load_i) cksum_q <= cksum_i;
   end
   assign slots_o[DATA_NIBS*NIB_W +: NIB_W] = cksum_q;

   // Checker: recompute the checksum from the stored slots.
   logic [NIB_W-1:0] chk_sum;
   always_comb begin
      chk_sum = '0;
      for (int i = 0; i < DATA_NIBS; i++) chk_sum = chk_sum + data_q[i];
   end

   assert_cksum_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_i) |-> (cksum_q == ~chk_sum));

   assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(slots_o));

   assert_reset_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (slots_o == {CKSUM_INIT[NIB_W-1:0], {(DATA_NIBS*NIB_W){1'b0}}}));

   localparam int unsigned SLOTS_CHK = SLOTS;
   if (SLOTS_CHK < 2) begin : g_bad_slots
      $error("dsf_frame_bank: need at least one data slot");
   end
endmodule

// File: rtl/dsf_host_regs.sv
// Host-writable command slots, control and fader registers.
module dsf_host_regs #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned CMD_BASE   = 10,
   parameter int unsigned CMD_SLOTS  = 10,
   parameter int unsigned CTRL_ADDR  = 20,
   parameter int unsigned FADER_ADDR = 21,
   parameter int unsigned CTRL_KEEP  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [ADDR_W-1:0]           wr_addr_i,
   input  logic [REG_W-1:0]            wr_data_i,
   input  logic                        export_i,
   output logic [CMD_SLOTS*REG_W-1:0]  cmd_o,
   output logic [REG_W-1:0]            ctrl_o,
   output logic [REG_W-1:0]            fader_o
);
   localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << CTRL_KEEP) - 1);

   if (CTRL_KEEP >= REG_W) begin : g_bad_keep
      $error("dsf_host_regs: CTRL_KEEP must be below REG_W");
   end
   if (FADER_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("dsf_host_regs: ADDR_W too narrow for the register map");
   end

   for (genvar i = 0; i < CMD_SLOTS; i++) begin : g_cmd
      logic [REG_W-1:0] cmd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cmd_q <= '0;
         else if (wr_en_i && wr_addr_i == ADDR_W'(CMD_BASE + i)) cmd_q <= wr_data_i;
      end
      assign cmd_o[i*REG_W +: REG_W] = cmd_q;
   end

   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] fader_q;

   // An export takes priority over a colliding host write.
   always_ff @(posedge clk) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (export_i) ctrl_q <= ctrl_q & KEEP_MASK;
      else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fader_q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(FADER_ADDR)) fader_q <= wr_data_i;
   end

   assign ctrl_o  = ctrl_q;
   assign fader_o = fader_q;

   assert_ctrl_trimmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      export_i |=> ((ctrl_o & ~KEEP_MASK) == '0));

   assert_ctrl_low_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      export_i |=> ((ctrl_o & KEEP_MASK) == ($past(ctrl_o) & KEEP_MASK)));

   assert_fader_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_W'(FADER_ADDR)) |=> (fader_o == $past(wr_data_i)));
endmodule

// File: rtl/dsf_irq.sv
// One-cycle interrupt request per enabled export.
module dsf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic export_i,
   input  logic enable_i,
   output logic irq_o
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= export_i & enable_i;
   end
   assign irq_o = irq_q;

   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(export_i) && $past(enable_i)));

   assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> !irq_o);
endmodule

// File: rtl/drive_status_frame.sv
// Drive status frame builder: nibble frame, checksum, host bank, interrupt.
module drive_status_frame
   import dsf_pkg::*;
#(
   parameter int unsigned NIB_W       = DSF_NIB_W,
   parameter int unsigned NIBS_PER_F  = 2,
   parameter int unsigned NUM_FIELDS  = 4,
   parameter int unsigned REG_W       = DSF_REG_W,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned CTRL_KEEP   = 2,
   parameter logic [3:0]  CKSUM_INIT  = DSF_CKSUM_INIT,
   parameter rd_mode_e    READ_MODE   = RD_COMB,
   localparam int unsigned FIELD_W    = NIB_W * NIBS_PER_F,
   localparam int unsigned DATA_NIBS  = NUM_FIELDS * NIBS_PER_F + 1,
   localparam int unsigned FRAME_SLOTS = DATA_NIBS + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_i,
   input  logic [NUM_FIELDS*FIELD_W-1:0]  fields_i,
   input  logic [NIB_W-1:0]               ext_i,
   input  logic                           irq_enable_i,
   input  logic                           wr_en_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [REG_W-1:0]               wr_data_i,
   input  logic [ADDR_W-1:0]              rd_addr_i,
   output logic [REG_W-1:0]               rd_data_o,
   output logic                           irq_o
);
   localparam int unsigned CMD_BASE   = FRAME_SLOTS;
   localparam int unsigned CMD_SLOTS  = FRAME_SLOTS;
   localparam int unsigned CTRL_ADDR  = CMD_BASE + CMD_SLOTS;
   localparam int unsigned FADER_ADDR = CTRL_ADDR + 1;

   if (NIB_W > REG_W) begin : g_bad_w
      $error("drive_status_frame: nibble wider than a register");
   end
   if (FADER_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("drive_status_frame: ADDR_W too narrow");
   end

   // Split fields into nibbles, most significant nibble in the lower slot.
   logic [DATA_NIBS*NIB_W-1:0] data_nibs;
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      for (genvar k = 0; k < NIBS_PER_F; k++) begin : g_nib
         assign data_nibs[(f*NIBS_PER_F + k)*NIB_W +: NIB_W] =
            fields_i[f*FIELD_W + (NIBS_PER_F-1-k)*NIB_W +: NIB_W];
      end
   end
   assign data_nibs[(DATA_NIBS-1)*NIB_W +: NIB_W] = ext_i;

   logic [NIB_W-1:0] cksum_next;
   dsf_checksum #(.NIB_W(NIB_W), .NUM_NIBS(DATA_NIBS)) cksum_i (
      .nibs_i  (data_nibs),
      .cksum_o (cksum_next)
   );

   logic [FRAME_SLOTS*NIB_W-1:0] frame_slots;
   dsf_frame_bank #(.NIB_W(NIB_W), .DATA_NIBS(DATA_NIBS), .CKSUM_INIT(CKSUM_INIT)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .data_i  (data_nibs),
      .cksum_i (cksum_next),
      .slots_o (frame_slots)
   );

   logic [CMD_SLOTS*REG_W-1:0] cmd_regs;
   logic [REG_W-1:0]           ctrl_reg;
   logic [REG_W-1:0]           fader_reg;
   dsf_host_regs #(
      .REG_W(REG_W), .ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CMD_SLOTS(CMD_SLOTS),
      .CTRL_ADDR(CTRL_ADDR), .FADER_ADDR(FADER_ADDR), .CTRL_KEEP(CTRL_KEEP)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .export_i  (load_i),
      .cmd_o     (cmd_regs),
      .ctrl_o    (ctrl_reg),
      .fader_o   (fader_reg)
   );

   dsf_irq irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .export_i (load_i),
      .enable_i (irq_enable_i),
      .irq_o    (irq_o)
   );

   // Host read multiplexer; unmapped addresses return zero.
   logic [REG_W-1:0] rd_comb;
   always_comb begin
      rd_comb = '0;
      for (int i = 0; i < FRAME_SLOTS; i++)
         if (rd_addr_i == ADDR_W'(i)) rd_comb = REG_W'(frame_slots[i*NIB_W +: NIB_W]);
      for (int i = 0; i < CMD_SLOTS; i++)
         if (rd_addr_i == ADDR_W'(CMD_BASE + i)) rd_comb = cmd_regs[i*REG_W +: REG_W];
      if (rd_addr_i == ADDR_W'(CTRL_ADDR))  rd_comb = ctrl_reg;
      if (rd_addr_i == ADDR_W'(FADER_ADDR)) rd_comb = fader_reg;
   end

   if (READ_MODE == RD_FLOP) begin : g_rd_flop
      logic [REG_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_comb;
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_comb;
   end

   assert_frame_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (READ_MODE == RD_COMB && rd_addr_i < ADDR_W'(FRAME_SLOTS)) |->
         ((rd_data_o >> NIB_W) == '0));
endmodule

// File: tb/drive_status_frame_tb_top.sv
module drive_status_frame_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        load_i;
   logic [31:0] fields_i;
   logic [3:0]  ext_i;
   logic        irq_enable_i;
   logic        wr_en_i;
   logic [4:0]  wr_addr_i;
   logic [7:0]  wr_data_i;
   logic [4:0]  rd_addr_i;
   logic [7:0]  rd_data_o;
   logic        irq_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   drive_status_frame dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .fields_i(fields_i), .ext_i(ext_i),
      .irq_enable_i(irq_enable_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr_i = a;
      #1;
      d = rd_data_o;
   endtask

   function automatic logic [3:0] exp_slot(input logic [31:0] f, input logic [3:0] e, input int s);
      logic [3:0] sum;
      if (s < 8) return f[(s/2)*8 + ((s%2) == 0 ? 4 : 0) +: 4];
      if (s == 8) return e;
      sum = e;
      for (int i = 0; i < 8; i++) sum = sum + f[i*4 +: 4];
      return ~sum;
   endfunction

   task automatic host_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // Returns irq_o as seen in the cycle after the load edge.
   task automatic do_load(input logic [31:0] f, input logic [3:0] e, input logic en,
                          output logic irq_seen);
      @(negedge clk);
      load_i = 1'b1; fields_i = f; ext_i = e; irq_enable_i = en;
      @(negedge clk);
      irq_seen = irq_o;
      load_i = 1'b0;
   endtask

   task automatic check_frame(input string req, input logic [31:0] f, input logic [3:0] e);
      logic [7:0] d;
      for (int s = 0; s < 10; s++) begin
         rd(5'(s), d);
         check(req, d, {4'h0, exp_slot(f, e, s)});
      end
   endtask

   task automatic t_reset;
      logic [7:0] d;
      for (int a = 0; a < 22; a++) begin
         rd(5'(a), d);
         check("R1", d, (a == 9) ? 8'h0F : 8'h00);
      end
   endtask

   task automatic t_placement;
      logic irq;
      do_load(32'h78563412, 4'h9, 1'b0, irq);
      check_frame("R2", 32'h78563412, 4'h9);
   endtask

   task automatic t_checksum;
      logic irq;
      logic [7:0] d;
      do_load(32'hFFFFFFFF, 4'hF, 1'b0, irq);
      rd(5'd9, d); check("R3 all ones", d, 8'h08);
      do_load(32'h00000000, 4'h0, 1'b0, irq);
      rd(5'd9, d); check("R3 all zero", d, 8'h0F);
      do_load(32'h78563412, 4'h9, 1'b0, irq);
      rd(5'd9, d); check("R3 ramp", d, 8'h02);
      do_load(32'hA5C3E1B7, 4'h6, 1'b0, irq);
      check_frame("R3 mixed", 32'hA5C3E1B7, 4'h6);
   endtask

   task automatic t_ctrl;
      logic irq;
      logic [7:0] d;
      host_wr(5'd20, 8'hFE);
      rd(5'd20, d); check("R4 pre", d, 8'hFE);
      do_load(32'h01020304, 4'h1, 1'b0, irq);
      rd(5'd20, d); check("R4 trim", d, 8'h02);
      // Colliding write and load: write dropped, trimmed value kept.
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = 5'd20; wr_data_i = 8'hF1; load_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; load_i = 1'b0;
      rd(5'd20, d); check("R4 collide", d, 8'h02);
   endtask

   task automatic t_irq;
      logic irq;
      do_load(32'h11223344, 4'h5, 1'b1, irq);
      check("R5 pulse", {7'd0, irq}, 8'h01);
      @(negedge clk);
      check("R5 single", {7'd0, irq_o}, 8'h00);
      do_load(32'h11223344, 4'h5, 1'b0, irq);
      check("R5 masked", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_host;
      logic irq;
      logic [7:0] d;
      do_load(32'h9ABCDEF0, 4'h3, 1'b0, irq);
      host_wr(5'd3, 8'h55);
      host_wr(5'd9, 8'hAA);
      host_wr(5'd12, 8'h3C);
      host_wr(5'd19, 8'hC3);
      host_wr(5'd21, 8'h7E);
      check_frame("R6 frame ro", 32'h9ABCDEF0, 4'h3);
      rd(5'd12, d); check("R6 cmd", d, 8'h3C);
      rd(5'd19, d); check("R6 cmd last", d, 8'hC3);
      rd(5'd21, d); check("R6 fader", d, 8'h7E);
   endtask

   task automatic t_hold;
      logic [7:0] d;
      fields_i = 32'h12345678; ext_i = 4'hE;
      repeat (5) @(negedge clk);
      check_frame("R7 hold", 32'h9ABCDEF0, 4'h3);
      rd(5'd22, d); check("R8 addr22", d, 8'h00);
      rd(5'd31, d); check("R8 addr31", d, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; load_i = 1'b0; fields_i = '0; ext_i = '0; irq_enable_i = 1'b0;
      wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_placement();
      t_checksum();
      t_ctrl();
      t_irq();
      t_host();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule